// File: doc/BRIEF.md
# Eight-Lane Sample Word Serializer

This block turns parallel conversion results into serial bit streams. Each sample delivers one 12-bit word for each of eight channels. The block shifts every word out on its own single-bit lane, one bit per cycle of a fast clock that runs at twelve times the sample rate. All lanes move in lockstep, and every word goes out least significant bit first.

Two companion clocks come from the same position counter and the same register stage as the data, so their edges keep a fixed phase against the bit stream:

- **Frame clock.** Runs at the sample rate. Its rising edge marks the first bit of each word.
- **Half-rate bit clock.** Runs at six times the sample rate. Every one of its edges falls on a bit boundary, so a receiver can capture on both edges.

A sample-valid strobe latches a new set of words into a hold stage. The serializer picks up that stage at each frame boundary. If no new words arrive, the previous set is sent again.

Top module: `adc_lane_serializer`

## Requirements
- R1: A frame lasts WORD_W (12) fast-clock cycles. Exactly one bit per lane is presented in each cycle, and a whole word is sent in each frame.
- R2: Bit i of a word (bit 0 = least significant) appears on its lane in the i-th cycle of the frame, counting from 0. The least significant bit is therefore sent first.
- R3: `frame_clk` is high for frame positions 0 to 5 and low for positions 6 to 11. Its rising edge coincides with bit 0 on every lane.
- R4: `half_bit_clk` is high at even frame positions and low at odd ones, so it changes level every fast-clock cycle while out of reset.
- R5: Channel c takes its word from `smp_data[c*12 +: 12]` and sends it on `lane_out[c]`. All eight lanes start their words in the same cycle.
- R6: A word set is captured at a clock edge where `smp_valid` is high. It is sent in the first frame that starts at a later edge.
- R7: If `smp_valid` is high at the very edge that starts a frame, that frame still carries the previously held words. The new words go out in the following frame.
- R8: While `smp_valid` is low, changes on `smp_data` have no effect, and the held word set is sent again in every frame.
- R9: While `rst` is high, all lanes and both companion clocks are low and the held words are cleared to zero. The first edge after `rst` falls presents position 0 of a frame carrying all-zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, twelve times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe: capture `smp_data` at this edge |
| smp_data | input | 96 | Eight 12-bit words, channel c in bits c*12 +: 12 |
| lane_out | output | 8 | One serial data lane per channel |
| frame_clk | output | 1 | Sample-rate frame clock, high during positions 0 to 5 |
| half_bit_clk | output | 1 | Six-times-rate clock, high at even positions |

## Verification
The hardest case to reach from the ports is a strobe that lands on the exact edge where a frame boundary reloads the shift registers. At that edge the hold stage and the shift registers both update, and only the hold stage's old contents may be sent. The bench reaches it by recovering a full frame from the lanes and then raising `smp_valid` in the twelfth sample of that frame, which is the last cycle before the next reload edge. It then checks that the frame starting at that edge still carries the old words and that the frame after it carries the new ones. A reset applied mid-frame is also used, to check that framing restarts at position 0 on the first edge after release.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned DEF_CHANNELS = 8;
  localparam int unsigned DEF_WORD_W   = 12;

  // Width of a counter that holds values 0 .. n-1 (at least one bit).
  function automatic int unsigned pos_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ser_frame_timer.sv
module ser_frame_timer
  import ser_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic clk,
  input  logic rst,
  output logic load,
  output logic frame_q,
  output logic clk6_q
);
  localparam int unsigned PW   = pos_bits(WORD_W);
  localparam int unsigned HALF = WORD_W / 2;

  // pos is the frame position presented at the next clock edge.
  logic [PW-1:0] pos;
  logic          started;

  assign load = (pos == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= '0;
      frame_q <= 1'b0;
      clk6_q  <= 1'b0;
      started <= 1'b0;
    end else begin
      pos     <= (pos == PW'(WORD_W - 1)) ? '0 : pos + 1'b1;
      frame_q <= (pos < PW'(HALF));
      clk6_q  <= ~pos[0];
      started <= 1'b1;
    end
  end

  // R4: the 6X clock changes level on every edge once running
  a_r4_half_clk_toggles: assert property (@(posedge clk) disable iff (rst)
    started |-> (clk6_q != $past(clk6_q)));

  // R3: the frame clock only changes while the 6X clock is high
  a_r3_frame_on_even_edge: assert property (@(posedge clk) disable iff (rst)
    (started && (frame_q != $past(frame_q))) |-> clk6_q);
endmodule

// File: rtl/ser_word_hold.sv
module ser_word_hold
  import ser_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_CHANNELS,
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cap_en,
  input  logic [NUM_CH*WORD_W-1:0] cap_bus,
  output logic [NUM_CH*WORD_W-1:0] held_bus
);
  always_ff @(posedge clk) begin
    if (rst)         held_bus <= '0;
    else if (cap_en) held_bus <= cap_bus;
  end

  // R8: without a strobe the held set stays unchanged
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(held_bus));
endmodule

// File: rtl/ser_lane.sv
module ser_lane
  import ser_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              bit_q
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      bit_q <= 1'b0;
    end else if (load) begin
      bit_q <= word[0];
      shreg <= word >> 1;
    end else begin
      bit_q <= shreg[0];
      shreg <= shreg >> 1;
    end
  end
endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
  import ser_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_CHANNELS,
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic [NUM_CH*WORD_W-1:0] smp_data,
  output logic [NUM_CH-1:0]        lane_out,
  output logic                     frame_clk,
  output logic                     half_bit_clk
);
  logic                     load;
  logic [NUM_CH*WORD_W-1:0] held_bus;
  logic [NUM_CH-1:0]        held_lsb;

  ser_frame_timer #(.WORD_W(WORD_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .frame_q (frame_clk),
    .clk6_q  (half_bit_clk)
  );

  ser_word_hold #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (smp_valid),
    .cap_bus  (smp_data),
    .held_bus (held_bus)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    assign held_lsb[c] = held_bus[c*WORD_W];
    ser_lane #(.WORD_W(WORD_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .word  (held_bus[c*WORD_W +: WORD_W]),
      .bit_q (lane_out[c])
    );
  end

  // R9: outputs are low in the cycle after reset is sampled
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (lane_out == '0 && !frame_clk && !half_bit_clk));

  // R3/R2: a frame clock rising edge carries bit 0 of the held words
  a_r2_lsb_at_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_clk) |-> (lane_out == $past(held_lsb)));
endmodule

// File: tb/sim_adc_lane_serializer.sv
module sim_adc_lane_serializer;
  localparam int CLK_P = 10;
  localparam int NCH   = 8;
  localparam int WW    = 12;
  localparam int NV    = 4;
  localparam logic [NCH*WW-1:0] VEC [NV] = '{
    96'h001_002_004_008_010_020_040_800,
    96'hFFF_000_AAA_555_123_456_789_ABC,
    96'h800_7FF_F0F_0F0_C3C_3C3_E01_01E,
    96'h5A5_A5A_FFE_001_999_666_ACE_531
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 smp_valid = 1'b0;
  logic [NCH*WW-1:0]    smp_data = '0;
  logic [NCH-1:0]       lane_out;
  logic                 frame_clk;
  logic                 half_bit_clk;

  int errors = 0;
  int checks = 0;
  logic prev_f = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  adc_lane_serializer u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .lane_out(lane_out), .frame_clk(frame_clk), .half_bit_clk(half_bit_clk)
  );

  task automatic check(input bit ok, input string req,
                       input logic [NCH*WW-1:0] act, input logic [NCH*WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    prev_f = frame_clk;
    @(negedge clk);
  endtask

  task automatic wait_start();
    do step(); while (!(frame_clk && !prev_f));
  endtask

  // Called at sample 0 of a frame; ends at sample WW-1.
  task automatic collect(output logic [NCH*WW-1:0] got, output int fbad, output int cbad);
    got = '0; fbad = 0; cbad = 0;
    for (int i = 0; i < WW; i++) begin
      if (i > 0) step();
      for (int c = 0; c < NCH; c++) got[c*WW + i] = lane_out[c];
      if (frame_clk !== (i < WW/2)) fbad++;
      if (half_bit_clk !== (i % 2 == 0)) cbad++;
    end
  endtask

  task automatic frame_check(input string tag, input logic [NCH*WW-1:0] exp);
    logic [NCH*WW-1:0] got;
    int fb, cb;
    collect(got, fb, cb);
    check(got === exp, {tag, " R1 R2 R5 word"}, got, exp);
    check(fb == 0, {tag, " R3 frame_clk shape"}, fb, 0);
    check(cb == 0, {tag, " R4 half_bit_clk shape"}, cb, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [NCH*WW-1:0] last;
    repeat (3) @(negedge clk);
    check({lane_out, frame_clk, half_bit_clk} === '0, "R9 outputs low in reset",
          {lane_out, frame_clk, half_bit_clk}, 0);
    rst = 1'b0;
    step();
    check(frame_clk === 1'b1 && half_bit_clk === 1'b1, "R9 first edge at position 0",
          {frame_clk, half_bit_clk}, 2'b11);
    frame_check("R9 cleared words", '0);

    last = '0;
    for (int v = 0; v < NV; v++) begin
      wait_start();
      smp_valid = 1'b1; smp_data = VEC[v];
      step();
      smp_valid = 1'b0; smp_data = ~VEC[v];   // R8: ignored while strobe low
      wait_start();
      frame_check("R6 vector", VEC[v]);
      wait_start();
      frame_check("R8 repeat", VEC[v]);
      last = VEC[v];
    end

    // R7: strobe on the reload edge (now at sample WW-1 of a frame)
    smp_valid = 1'b1; smp_data = VEC[0];
    step();
    smp_valid = 1'b0; smp_data = '0;
    frame_check("R7 old words kept", last);
    wait_start();
    frame_check("R7 new words next", VEC[0]);

    // R9: reset in the middle of a frame
    wait_start();
    repeat (4) step();
    rst = 1'b1;
    step(); step();
    check({lane_out, frame_clk, half_bit_clk} === '0, "R9 mid-frame reset quiet",
          {lane_out, frame_clk, half_bit_clk}, 0);
    rst = 1'b0;
    step();
    check(frame_clk === 1'b1 && prev_f === 1'b0, "R9 restart at frame start",
          {prev_f, frame_clk}, 2'b01);
    frame_check("R9 words cleared after reset", '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule